// File: doc/BRIEF.md
# Bidirectional Serial-to-Parallel Latched Driver

This block converts a serial bit stream into 64 parallel driver outputs for a row or column of a display. Bits enter a 64-stage shift register on each rising clock edge. A direction input selects which way they travel. It also selects which of the two serial ports is the data input and which one carries the cascade output to the next device in a chain. Each serial port is modelled as a separate input, output and output-enable signal. Only the port that acts as the cascade output has its enable asserted.

A bank of latches sits between the shift register and the outputs. The latches follow the register while the load strobe is high and freeze when it goes low. The register can then fill with the next line while the display shows the current one. An output stage combines a blanking input, active low, with a polarity input. Together they select one of four modes: all outputs high, all outputs low, latched data as stored, or latched data inverted.

Top module: `serpar_drv`

## Requirements
- R1: A synchronous active-high reset clears all 64 shift stages and all 64 latches to zero.
- R2: With `dir` = 1, each rising edge loads `a_in` into stage 1 and moves every stage k into stage k+1. `b_out` shows stage 64.
- R3: With `dir` = 0, each rising edge loads `b_in` into stage 64 and moves every stage k into stage k-1. `a_out` shows stage 1.
- R4: `b_oe` equals `dir` and `a_oe` equals the inverse of `dir`, so only the cascade port drives.
- R5: `latch_en`, `show_n` and `pol` have no effect on shifting or on the cascade output.
- R6: While `latch_en` is 1, the latches are transparent and pass the current stage contents to the output stage.
- R7: While `latch_en` is 0, the latches hold the value they had when `latch_en` was last high, even while the register keeps shifting.
- R8: With `show_n` = 0, every bit of `drv` is 1 when `pol` = 0 and 0 when `pol` = 1.
- R9: With `show_n` = 1, `drv[k]` equals latch k when `pol` = 1 and its inverse when `pol` = 0.
- R10: A change on `dir` leaves the stored stages untouched. The new direction applies from the next rising edge, and the cascade pin moves at once to the stage at the new end.
- R11: Stage 1 maps to `drv[0]` and stage 64 maps to `drv[63]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir | input | 1 | 1: shift stage 1 toward stage 64; 0: the reverse |
| a_in | input | 1 | Serial data in on port A (used when dir = 1) |
| a_out | output | 1 | Cascade out on port A (stage 1) |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | 1 | Serial data in on port B (used when dir = 0) |
| b_out | output | 1 | Cascade out on port B (stage 64) |
| b_oe | output | 1 | Port B drive enable |
| latch_en | input | 1 | Latch strobe, transparent when high |
| show_n | input | 1 | Blanking control; 0 forces all outputs |
| pol | input | 1 | Polarity; 1 gives true data, 0 gives inverted data |
| drv | output | 64 | Conditioned latch outputs; bit 0 is output 1 |

## Verification
The bench goes after these corner cases:
- **Direction flip with a full register.** It checks that both cascade pins show the two end stages before the next edge. A design that cleared stages or shifted on the flip would show the wrong end bits.
- **Latch hold.** It holds `latch_en` low for long random runs while the register keeps shifting. A design whose latches leak would let the outputs follow the moving data.
- **Output modes under random patterns.** It walks all four blanking and polarity modes. Swapped decoding shows up as an all-high/all-low mix-up or as true/inverted data.
- **Single-bit trace.** After reset it sends one bit through in each direction. An off-by-one stage or a reversed output index puts the bit on the wrong output or the wrong cascade cycle.

// File: rtl/serpar_drv.sv
module serpar_drv #(
  parameter int CH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir,
  input  logic          a_in,
  output logic          a_out,
  output logic          a_oe,
  input  logic          b_in,
  output logic          b_out,
  output logic          b_oe,
  input  logic          latch_en,
  input  logic          show_n,
  input  logic          pol,
  output logic [CH-1:0] drv
);
  logic [CH-1:0] sr, sr_nx, held, lat;

  assign sr_nx = dir ? {sr[CH-2:0], a_in} : {b_in, sr[CH-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      held <= '0;
    end else begin
      sr <= sr_nx;
      if (latch_en) held <= sr_nx;
    end
  end

  assign lat   = latch_en ? sr : held;
  assign drv   = show_n ? (pol ? lat : ~lat) : {CH{~pol}};
  assign a_out = sr[0];
  assign b_out = sr[CH-1];
  assign a_oe  = ~dir;
  assign b_oe  = dir;
endmodule

module serpar_drv_chk #(
  parameter int CH = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          dir,
  input logic          a_in,
  input logic          b_in,
  input logic          a_oe,
  input logic          b_oe,
  input logic          latch_en,
  input logic          show_n,
  input logic          pol,
  input logic [CH-1:0] sr,
  input logic [CH-1:0] drv
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(rst)) |-> (sr == '0));
  // R2
  fwd_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && $past(dir)) |-> (sr == {$past(sr[CH-2:0]), $past(a_in)}));
  // R3
  rev_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && !$past(dir)) |-> (sr == {$past(b_in), $past(sr[CH-1:1])}));
  // R4
  oe_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (b_oe == dir) && (a_oe == !dir));
  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && !latch_en && !$past(latch_en) && $stable(show_n) && $stable(pol))
      |-> $stable(drv));
  // R8
  forced_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !show_n |-> (drv == {CH{!pol}}));
endmodule

bind serpar_drv serpar_drv_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst(rst), .dir(dir), .a_in(a_in), .b_in(b_in),
  .a_oe(a_oe), .b_oe(b_oe), .latch_en(latch_en), .show_n(show_n),
  .pol(pol), .sr(sr), .drv(drv)
);

// File: tb/tb_serpar_drv.sv
module tb_serpar_drv;
  localparam int CH = 64;

  logic clk = 1'b0;
  logic rst, dir, a_in, b_in, latch_en, show_n, pol;
  logic a_out, a_oe, b_out, b_oe;
  logic [CH-1:0] drv;

  logic [CH-1:0] m_sr, m_hold;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serpar_drv #(.CH(CH)) dut (
    .clk(clk), .rst(rst), .dir(dir), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .latch_en(latch_en),
    .show_n(show_n), .pol(pol), .drv(drv)
  );

  function automatic logic [CH-1:0] exp_drv(input logic [CH-1:0] lat, input logic s, input logic p);
    if (!s) return {CH{~p}};
    return p ? lat : ~lat;
  endfunction

  task automatic chk(input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    string tag;
    logic [CH-1:0] lat;
    lat = latch_en ? m_sr : m_hold;
    tag = latch_en ? "R6" : "R7";
    tag = {tag, show_n ? " R9" : " R8"};
    chk(tag, drv, exp_drv(lat, show_n, pol));
    if (dir) chk("R2 R5 cascade", CH'(b_out), CH'(m_sr[CH-1]));
    else     chk("R3 R5 cascade", CH'(a_out), CH'(m_sr[0]));
    chk("R4 oe", CH'({a_oe, b_oe}), CH'({~dir, dir}));
  endtask

  task automatic step(input logic r, input logic d, input logic ai, input logic bi,
                      input logic le, input logic s, input logic p);
    rst = r; dir = d; a_in = ai; b_in = bi; latch_en = le; show_n = s; pol = p;
    @(posedge clk);
    if (r) begin
      m_sr = '0; m_hold = '0;
    end else begin
      m_sr = d ? {m_sr[CH-2:0], ai} : {bi, m_sr[CH-1:1]};
      if (le) m_hold = m_sr;
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_sr = '0; m_hold = '0;
    rst = 1; dir = 1; a_in = 0; b_in = 0; latch_en = 0; show_n = 1; pol = 1;
    @(negedge clk);
    // R1: reset clears register and latches
    step(1, 1, 1, 1, 0, 1, 1);
    chk("R1 reset drv", drv, '0);
    step(0, 1, 0, 0, 1, 1, 1);
    chk("R1 reset after", drv, '0);

    // R11: one bit into stage 1 lands on drv[0]
    step(0, 1, 1, 0, 1, 1, 1);
    chk("R11 first stage", drv, CH'(1));
    for (int i = 0; i < CH - 1; i++) step(0, 1, 0, 0, 1, 1, 1);
    chk("R11 last stage", drv, {1'b1, {(CH-1){1'b0}}});
    chk("R2 cascade end", CH'(b_out), CH'(1));

    // R3: reverse walk of a single bit back to stage 1
    step(1, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 1, 1, 1, 1);
    chk("R3 entry stage", drv, {1'b1, {(CH-1){1'b0}}});
    for (int i = 0; i < CH - 1; i++) step(0, 0, 0, 0, 1, 1, 1);
    chk("R3 exit stage", drv, CH'(1));

    // R10: fill a pattern, then flip direction between edges
    for (int i = 0; i < CH; i++) step(0, 1, 1'(i % 3 == 0), 0, 1, 1, 1);
    dir = 0;
    #1;
    chk("R10 a_out at flip", CH'(a_out), CH'(m_sr[0]));
    chk("R10 b_out at flip", CH'(b_out), CH'(m_sr[CH-1]));
    chk("R10 contents at flip", drv, m_sr);
    step(0, 0, 0, 1, 1, 1, 1);

    // R7: hold with latch low while shifting
    step(0, 1, 1, 0, 1, 1, 1);
    for (int i = 0; i < 80; i++) step(0, 1, 1'($urandom), 1'($urandom), 0, 1, 1);

    // R8 R9: all four modes on held data
    step(0, 1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 1);
    step(0, 1, 0, 0, 0, 1, 0);
    step(0, 1, 0, 0, 0, 1, 1);

    // random mix, R5 via cascade under random control inputs
    for (int i = 0; i < 3000; i++) begin
      logic ld;
      ld = ($urandom % 8) == 0;
      step(ld ? (($urandom % 50) == 0) : 1'b0,
           ($urandom % 200) < 190 ? dir : ~dir,
           1'($urandom), 1'($urandom), ld ? 1'b1 : (($urandom % 6) == 0),
           1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule